// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block performs the control-register updates a CPU makes when it takes an event: a general exception, a TLB-miss exception, a trap instruction, an interrupt or a reset. The pipeline presents the event kind, its event code, an alternate code for the delay-slot case and the delay-slot status, together with the current program counter, status register, the live T/S/M/Q flags and the stack pointer (R15).

On the clock edge that samples a request, the block saves the PC, the merged status word and the stack pointer into shadow registers. It writes the event code into the exception-event or interrupt-event register and computes the new PC from the vector base. It also forces the privileged, blocked and bank-1 bits in the new status word. Reset entries go to a fixed vector that ignores the vector base and clear that base. Flushing the pipeline and choosing among interrupts belong to other blocks.

Top module: `exc_entry_seq`

## Requirements
- R1: After `rst_n` is low, `new_pc` is 0xA0000000, `new_sr` is 0x700000F0, and `vbr`, `spc`, `ssr`, `sgr`, `expevt`, `intevt`, `tra`, `slot_clr` and `entry_done` are all 0.
- R2: For kinds general (0), TLB miss (1), trap (2) and interrupt (3), `ssr` receives the merged status word. The merged word is `cur_sr` with bit 0 replaced by `flag_t`, bit 1 by `flag_s`, bit 8 by `flag_q` and bit 9 by `flag_m`. In the same entry `sgr` receives `cur_r15`.
- R3: After such an entry, `new_sr` equals the merged word with bits 30 (privileged), 29 (bank) and 28 (block) set.
- R4: `new_pc` becomes the vector base plus 0x100 for general exceptions and traps, plus 0x400 for TLB misses, and plus 0x600 for interrupts. A `vbr_we` write in the same cycle does not affect the vector used.
- R5: For kinds 0, 1 and 2 with `in_slot` high, `spc` is `cur_pc` minus 2 and `slot_clr` pulses. Otherwise `spc` is `cur_pc`. Interrupts never apply this correction and never pulse `slot_clr`.
- R6: For kinds 0 and 1, `expevt` takes `slot_code` when `in_slot` is high and `evt_code` otherwise. For an interrupt, `intevt` takes `evt_code` and `expevt` keeps its value.
- R7: A trap writes `trap_imm` shifted left by 2 into `tra` and writes 0x160 into `expevt`.
- R8: A reset request (kind 4) sets `new_pc` to 0xA0000000 and `vbr` to 0. It writes 0x000 into `expevt`, sets bits 30, 29, 28 and 7:4 of the merged word and clears bit 15, and leaves `spc`, `ssr`, `sgr`, `intevt` and `tra` unchanged.
- R9: A request of kind 0 to 3 that arrives while bit 28 of `cur_sr` is set takes the reset entry of R8, except that `expevt` receives 0x020.
- R10: Kinds 5 to 7, and cycles with `req_valid` low, change no output except `vbr`. `vbr` takes `vbr_wdata` when `vbr_we` is high and no reset entry occurs.
- R11: `entry_done` is high for exactly the cycle after each accepted request of kind 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Event request strobe |
| req_kind | input | 3 | Event kind, 0 general, 1 TLB miss, 2 trap, 3 interrupt, 4 reset |
| evt_code | input | 12 | Event code for the normal case or the interrupt |
| slot_code | input | 12 | Event code used when the faulting instruction is in a delay slot |
| in_slot | input | 1 | Faulting instruction sits in a branch delay slot |
| trap_imm | input | 8 | Trap instruction immediate |
| cur_pc | input | 32 | Current program counter |
| cur_sr | input | 32 | Current status register |
| flag_t | input | 1 | Live T flag |
| flag_s | input | 1 | Live S flag |
| flag_m | input | 1 | Live M flag |
| flag_q | input | 1 | Live Q flag |
| cur_r15 | input | 32 | Current stack pointer |
| vbr_we | input | 1 | Vector base write enable |
| vbr_wdata | input | 32 | Vector base write data |
| new_pc | output | 32 | Program counter after entry |
| new_sr | output | 32 | Status register after entry |
| spc | output | 32 | Saved program counter |
| ssr | output | 32 | Saved status register |
| sgr | output | 32 | Saved stack pointer |
| expevt | output | 12 | Exception event code |
| intevt | output | 12 | Interrupt event code |
| tra | output | 10 | Trap code (immediate times four) |
| vbr | output | 32 | Vector base |
| slot_clr | output | 1 | Pulse: clear the pipeline's delay-slot flag |
| entry_done | output | 1 | Pulse: an entry was taken |

## Verification
The bench sweeps every kind code, both delay-slot states and both block-bit states against several PCs, flag mixes and vector bases. Each result is compared with a model built from the requirements. A design that corrected the saved PC on interrupts, or forgot the correction on traps, would return to the wrong instruction, and the R5 checks on `spc` catch it. Other faults the sweep targets are a TLB miss sent to the general vector, an entry that used a vector base written in the same cycle, and a blocked request that entered normally instead of resetting. Each of these shows up as a wrong `new_pc` or `expevt`. The sweep also covers an unmerged flag in `ssr` and a reset that kept FD set or failed to clear the vector base.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
   typedef enum logic [2:0] {
      K_GENERAL = 3'd0,
      K_TLB     = 3'd1,
      K_TRAP    = 3'd2,
      K_IRQ     = 3'd3,
      K_RESET   = 3'd4
   } req_kind_e;

   typedef enum logic [1:0] {
      ROUTE_NONE = 2'd0,
      ROUTE_EXC  = 2'd1,
      ROUTE_IRQ  = 2'd2,
      ROUTE_RST  = 2'd3
   } route_e;

   localparam int unsigned SR_T       = 0;
   localparam int unsigned SR_S       = 1;
   localparam int unsigned SR_IMSK_LO = 4;
   localparam int unsigned SR_IMSK_HI = 7;
   localparam int unsigned SR_Q       = 8;
   localparam int unsigned SR_M       = 9;
   localparam int unsigned SR_FD      = 15;
   localparam int unsigned SR_BL      = 28;
   localparam int unsigned SR_RB      = 29;
   localparam int unsigned SR_MD      = 30;
endpackage

// File: rtl/exc_route.sv
module exc_route
   import exc_seq_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned CODE_W     = 12,
   parameter logic [31:0] GEN_OFF    = 32'h100,
   parameter logic [31:0] TLB_OFF    = 32'h400,
   parameter logic [31:0] IRQ_OFF    = 32'h600,
   parameter logic [11:0] TRAP_CODE  = 12'h160,
   parameter logic [11:0] POR_CODE   = 12'h000,
   parameter logic [11:0] BLK_CODE   = 12'h020
) (
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic              blocked,
   input  logic              in_slot,
   input  logic [CODE_W-1:0] evt_code,
   input  logic [CODE_W-1:0] slot_code,
   output route_e            route,
   output logic [CODE_W-1:0] code_out,
   output logic [XLEN-1:0]   vec_off,
   output logic              fix_slot,
   output logic              wr_tra
);
   localparam int unsigned KIND_MAX = 4;

   logic kind_ok;
   assign kind_ok = (int'(req_kind) <= KIND_MAX);

   always_comb begin
      route    = ROUTE_NONE;
      code_out = '0;
      vec_off  = '0;
      fix_slot = 1'b0;
      wr_tra   = 1'b0;
      if (req_valid && kind_ok) begin
         if (req_kind == K_RESET) begin
            route    = ROUTE_RST;
            code_out = CODE_W'(POR_CODE);
         end else if (blocked) begin
            route    = ROUTE_RST;
            code_out = CODE_W'(BLK_CODE);
         end else begin
            unique case (req_kind)
               K_GENERAL, K_TLB: begin
                  route    = ROUTE_EXC;
                  code_out = in_slot ? slot_code : evt_code;
                  vec_off  = (req_kind == K_TLB) ? XLEN'(TLB_OFF) : XLEN'(GEN_OFF);
                  fix_slot = in_slot;
               end
               K_TRAP: begin
                  route    = ROUTE_EXC;
                  code_out = CODE_W'(TRAP_CODE);
                  vec_off  = XLEN'(GEN_OFF);
                  fix_slot = in_slot;
                  wr_tra   = 1'b1;
               end
               default: begin
                  route    = ROUTE_IRQ;
                  code_out = evt_code;
                  vec_off  = XLEN'(IRQ_OFF);
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/exc_sr_build.sv
module exc_sr_build
   import exc_seq_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic [XLEN-1:0] cur_sr,
   input  logic            flag_t,
   input  logic            flag_s,
   input  logic            flag_m,
   input  logic            flag_q,
   output logic [XLEN-1:0] merged_sr,
   output logic [XLEN-1:0] entry_sr,
   output logic [XLEN-1:0] reset_sr
);
   logic [XLEN-1:0] force_bits;
   logic [XLEN-1:0] imask_bits;

   for (genvar i = 0; i < XLEN; i++) begin : g_bit
      if (i == SR_T) begin : g_t
         assign merged_sr[i] = flag_t;
      end else if (i == SR_S) begin : g_s
         assign merged_sr[i] = flag_s;
      end else if (i == SR_Q) begin : g_q
         assign merged_sr[i] = flag_q;
      end else if (i == SR_M) begin : g_m
         assign merged_sr[i] = flag_m;
      end else begin : g_pass
         assign merged_sr[i] = cur_sr[i];
      end
      assign force_bits[i] = (i == SR_MD) || (i == SR_RB) || (i == SR_BL);
      assign imask_bits[i] = (i >= SR_IMSK_LO) && (i <= SR_IMSK_HI);
   end

   assign entry_sr = merged_sr | force_bits;
   always_comb begin
      reset_sr        = merged_sr | force_bits | imask_bits;
      reset_sr[SR_FD] = 1'b0;
   end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_seq_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned CODE_W     = 12,
   parameter int unsigned IMM_W      = 8,
   parameter int unsigned INSN_BYTES = 2,
   parameter bit          VEC_USE_OR = 1'b0,
   parameter logic [31:0] RESET_PC   = 32'hA000_0000,
   parameter logic [31:0] RESET_SR   = 32'h7000_00F0,
   parameter logic [31:0] GEN_OFF    = 32'h100,
   parameter logic [31:0] TLB_OFF    = 32'h400,
   parameter logic [31:0] IRQ_OFF    = 32'h600,
   parameter logic [11:0] TRAP_CODE  = 12'h160,
   parameter logic [11:0] POR_CODE   = 12'h000,
   parameter logic [11:0] BLK_CODE   = 12'h020
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic [CODE_W-1:0] evt_code,
   input  logic [CODE_W-1:0] slot_code,
   input  logic              in_slot,
   input  logic [IMM_W-1:0]  trap_imm,
   input  logic [XLEN-1:0]   cur_pc,
   input  logic [XLEN-1:0]   cur_sr,
   input  logic              flag_t,
   input  logic              flag_s,
   input  logic              flag_m,
   input  logic              flag_q,
   input  logic [XLEN-1:0]   cur_r15,
   input  logic              vbr_we,
   input  logic [XLEN-1:0]   vbr_wdata,
   output logic [XLEN-1:0]   new_pc,
   output logic [XLEN-1:0]   new_sr,
   output logic [XLEN-1:0]   spc,
   output logic [XLEN-1:0]   ssr,
   output logic [XLEN-1:0]   sgr,
   output logic [CODE_W-1:0] expevt,
   output logic [CODE_W-1:0] intevt,
   output logic [IMM_W+1:0]  tra,
   output logic [XLEN-1:0]   vbr,
   output logic              slot_clr,
   output logic              entry_done
);
   localparam int unsigned TRA_W = IMM_W + 2;

   initial begin
      assert (XLEN >= 31) else $error("XLEN too small for the status bit layout");
      assert (CODE_W >= 12) else $error("CODE_W must hold a 12-bit event code");
      assert (TRA_W <= XLEN) else $error("trap code wider than a word");
      assert (INSN_BYTES > 0) else $error("INSN_BYTES must be nonzero");
   end

   route_e            route;
   logic [CODE_W-1:0] code;
   logic [XLEN-1:0]   vec_off;
   logic              fix_slot;
   logic              wr_tra;
   logic [XLEN-1:0]   merged_sr;
   logic [XLEN-1:0]   entry_sr;
   logic [XLEN-1:0]   reset_sr;
   logic [XLEN-1:0]   target_pc;
   logic [XLEN-1:0]   saved_pc;

   logic [XLEN-1:0]   pc_q, sr_q, spc_q, ssr_q, sgr_q, vbr_q;
   logic [CODE_W-1:0] expevt_q, intevt_q;
   logic [TRA_W-1:0]  tra_q;
   logic              slot_clr_q, done_q;

   exc_route #(
      .XLEN(XLEN), .CODE_W(CODE_W),
      .GEN_OFF(GEN_OFF), .TLB_OFF(TLB_OFF), .IRQ_OFF(IRQ_OFF),
      .TRAP_CODE(TRAP_CODE), .POR_CODE(POR_CODE), .BLK_CODE(BLK_CODE)
   ) i_route (
      .req_valid (req_valid),
      .req_kind  (req_kind),
      .blocked   (cur_sr[SR_BL]),
      .in_slot   (in_slot),
      .evt_code  (evt_code),
      .slot_code (slot_code),
      .route     (route),
      .code_out  (code),
      .vec_off   (vec_off),
      .fix_slot  (fix_slot),
      .wr_tra    (wr_tra)
   );

   exc_sr_build #(.XLEN(XLEN)) i_sr (
      .cur_sr    (cur_sr),
      .flag_t    (flag_t),
      .flag_s    (flag_s),
      .flag_m    (flag_m),
      .flag_q    (flag_q),
      .merged_sr (merged_sr),
      .entry_sr  (entry_sr),
      .reset_sr  (reset_sr)
   );

   if (VEC_USE_OR) begin : g_vec_or
      assign target_pc = vbr_q | vec_off;
   end else begin : g_vec_add
      assign target_pc = vbr_q + vec_off;
   end

   assign saved_pc = fix_slot ? (cur_pc - XLEN'(INSN_BYTES)) : cur_pc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q       <= XLEN'(RESET_PC);
         sr_q       <= XLEN'(RESET_SR);
         spc_q      <= '0;
         ssr_q      <= '0;
         sgr_q      <= '0;
         vbr_q      <= '0;
         expevt_q   <= '0;
         intevt_q   <= '0;
         tra_q      <= '0;
         slot_clr_q <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         slot_clr_q <= 1'b0;
         done_q     <= 1'b0;
         if (vbr_we) vbr_q <= vbr_wdata;
         unique case (route)
            ROUTE_EXC: begin
               pc_q       <= target_pc;
               sr_q       <= entry_sr;
               spc_q      <= saved_pc;
               ssr_q      <= merged_sr;
               sgr_q      <= cur_r15;
               expevt_q   <= code;
               slot_clr_q <= fix_slot;
               done_q     <= 1'b1;
               if (wr_tra) tra_q <= {trap_imm, 2'b00};
            end
            ROUTE_IRQ: begin
               pc_q     <= target_pc;
               sr_q     <= entry_sr;
               spc_q    <= cur_pc;
               ssr_q    <= merged_sr;
               sgr_q    <= cur_r15;
               intevt_q <= code;
               done_q   <= 1'b1;
            end
            ROUTE_RST: begin
               pc_q     <= XLEN'(RESET_PC);
               sr_q     <= reset_sr;
               vbr_q    <= '0;
               expevt_q <= code;
               done_q   <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign new_pc     = pc_q;
   assign new_sr     = sr_q;
   assign spc        = spc_q;
   assign ssr        = ssr_q;
   assign sgr        = sgr_q;
   assign vbr        = vbr_q;
   assign expevt     = expevt_q;
   assign intevt     = intevt_q;
   assign tra        = tra_q;
   assign slot_clr   = slot_clr_q;
   assign entry_done = done_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned CODE_W     = 12,
   parameter int unsigned IMM_W      = 8,
   parameter bit          VEC_USE_OR = 1'b0,
   parameter logic [31:0] RESET_PC   = 32'hA000_0000,
   parameter logic [31:0] IRQ_OFF    = 32'h600,
   parameter logic [11:0] BLK_CODE   = 12'h020
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [2:0]        req_kind,
   input logic [XLEN-1:0]   cur_sr,
   input logic [IMM_W-1:0]  trap_imm,
   input logic              vbr_we,
   input logic [XLEN-1:0]   new_pc,
   input logic [XLEN-1:0]   new_sr,
   input logic [XLEN-1:0]   spc,
   input logic [CODE_W-1:0] expevt,
   input logic [IMM_W+1:0]  tra,
   input logic [XLEN-1:0]   vbr,
   input logic              slot_clr,
   input logic              entry_done
);
   p_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind <= 3'd4) |=> entry_done);

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((!req_valid || req_kind > 3'd4) && !vbr_we) |=>
         (!entry_done && $stable(new_pc) && $stable(new_sr) && $stable(spc)
          && $stable(expevt) && $stable(vbr)));

   p_sr_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
      entry_done |-> (new_sr[30] && new_sr[29] && new_sr[28]));

   p_irq_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!VEC_USE_OR && req_valid && req_kind == 3'd3 && !cur_sr[28]) |=>
         (new_pc == $past(vbr) + XLEN'(IRQ_OFF)));

   p_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      slot_clr |-> entry_done);

   p_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 3'd2 && !cur_sr[28]) |=> (tra == {$past(trap_imm), 2'b00}));

   p_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 3'd4) |=>
         (new_pc == XLEN'(RESET_PC) && vbr == '0 && !new_sr[15]));

   p_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind < 3'd4 && cur_sr[28]) |=>
         (new_pc == XLEN'(RESET_PC) && expevt == CODE_W'(BLK_CODE)));
endmodule

bind exc_entry_seq exc_entry_chk #(
   .XLEN(XLEN), .CODE_W(CODE_W), .IMM_W(IMM_W), .VEC_USE_OR(VEC_USE_OR),
   .RESET_PC(RESET_PC), .IRQ_OFF(IRQ_OFF), .BLK_CODE(BLK_CODE)
) i_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
   .cur_sr(cur_sr), .trap_imm(trap_imm), .vbr_we(vbr_we),
   .new_pc(new_pc), .new_sr(new_sr), .spc(spc), .expevt(expevt),
   .tra(tra), .vbr(vbr), .slot_clr(slot_clr), .entry_done(entry_done)
);

// File: tb/test_exc_entry_seq.sv
`timescale 1ns/1ps
module test_exc_entry_seq;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [2:0]  req_kind;
   logic [11:0] evt_code, slot_code;
   logic        in_slot;
   logic [7:0]  trap_imm;
   logic [31:0] cur_pc, cur_sr, cur_r15, vbr_wdata;
   logic        flag_t, flag_s, flag_m, flag_q, vbr_we;
   logic [31:0] new_pc, new_sr, spc, ssr, sgr, vbr;
   logic [11:0] expevt, intevt;
   logic [9:0]  tra;
   logic        slot_clr, entry_done;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   exc_entry_seq i_exc_entry_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .evt_code(evt_code), .slot_code(slot_code), .in_slot(in_slot),
      .trap_imm(trap_imm), .cur_pc(cur_pc), .cur_sr(cur_sr),
      .flag_t(flag_t), .flag_s(flag_s), .flag_m(flag_m), .flag_q(flag_q),
      .cur_r15(cur_r15), .vbr_we(vbr_we), .vbr_wdata(vbr_wdata),
      .new_pc(new_pc), .new_sr(new_sr), .spc(spc), .ssr(ssr), .sgr(sgr),
      .expevt(expevt), .intevt(intevt), .tra(tra), .vbr(vbr),
      .slot_clr(slot_clr), .entry_done(entry_done)
   );

   // expected state, built from the requirements
   logic [31:0] m_pc, m_sr, m_spc, m_ssr, m_sgr, m_vbr;
   logic [11:0] m_exp, m_int;
   logic [9:0]  m_tra;
   logic        m_slot, m_done;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      chk(req, "new_pc", new_pc, m_pc);
      chk(req, "new_sr", new_sr, m_sr);
      chk(req, "spc", spc, m_spc);
      chk(req, "ssr", ssr, m_ssr);
      chk(req, "sgr", sgr, m_sgr);
      chk(req, "expevt", {20'd0, expevt}, {20'd0, m_exp});
      chk(req, "intevt", {20'd0, intevt}, {20'd0, m_int});
      chk(req, "tra", {22'd0, tra}, {22'd0, m_tra});
      chk(req, "vbr", vbr, m_vbr);
      chk(req, "slot_clr", {31'd0, slot_clr}, {31'd0, m_slot});
      chk("R11", "entry_done", {31'd0, entry_done}, {31'd0, m_done});
   endtask

   function automatic logic [31:0] merge(input logic [31:0] s, input logic t, input logic ss,
                                         input logic m, input logic q);
      merge = (s & ~32'h0000_0303) | {22'd0, m, q, 6'd0, ss, t};
   endfunction

   task automatic idle_inputs();
      req_valid = 1'b0; req_kind = 3'd0; vbr_we = 1'b0;
   endtask

   // model one request cycle (R2..R10)
   task automatic model_req(input logic [2:0] k, input logic sl, input logic [31:0] vb_old);
      logic [31:0] mg;
      mg = merge(cur_sr, flag_t, flag_s, flag_m, flag_q);
      m_slot = 1'b0;
      m_done = 1'b0;
      if (k <= 3'd4) begin
         m_done = 1'b1;
         if (k == 3'd4 || cur_sr[28]) begin
            m_pc  = 32'hA000_0000;
            m_vbr = 32'h0;
            m_sr  = (mg | 32'h7000_00F0) & ~32'h0000_8000;
            m_exp = (k == 3'd4) ? 12'h000 : 12'h020;
         end else begin
            m_sr  = mg | 32'h7000_0000;
            m_ssr = mg;
            m_sgr = cur_r15;
            if (k == 3'd3) begin
               m_pc  = vb_old + 32'h600;
               m_spc = cur_pc;
               m_int = evt_code;
            end else begin
               m_pc   = vb_old + ((k == 3'd1) ? 32'h400 : 32'h100);
               m_spc  = sl ? cur_pc - 32'd2 : cur_pc;
               m_slot = sl;
               if (k == 3'd2) begin
                  m_exp = 12'h160;
                  m_tra = {trap_imm, 2'b00};
               end else begin
                  m_exp = sl ? slot_code : evt_code;
               end
            end
         end
      end
   endtask

   initial begin : watchdog
      while (cycles < 100000 && !finished) begin
         @(posedge clk);
         cycles++;
      end
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] vb;
      rst_n = 1'b0;
      idle_inputs();
      evt_code = '0; slot_code = '0; in_slot = 1'b0; trap_imm = '0;
      cur_pc = '0; cur_sr = '0; cur_r15 = '0; vbr_wdata = '0;
      flag_t = 0; flag_s = 0; flag_m = 0; flag_q = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_pc = 32'hA000_0000; m_sr = 32'h7000_00F0; m_spc = 0; m_ssr = 0; m_sgr = 0;
      m_vbr = 0; m_exp = 0; m_int = 0; m_tra = 0; m_slot = 0; m_done = 0;
      check_all("R1");

      for (int it = 0; it < 64; it++) begin
         // write a vector base (R10)
         @(negedge clk);
         vb = 32'h8C00_0000 + (it * 32'h0001_1000);
         vbr_we = 1'b1; vbr_wdata = vb;
         @(negedge clk);
         idle_inputs();
         m_vbr = vb; m_done = 0; m_slot = 0;
         check_all("R10");
         // the request, with a colliding vbr write on odd iterations (R4)
         req_valid = 1'b1;
         req_kind  = it[2:0];
         in_slot   = it[3];
         cur_sr    = (32'h4000_83F3 ^ (it * 32'h0101_0101)) & ~32'h1000_0000;
         cur_sr[28] = it[4];
         flag_t = it[0]; flag_s = it[1]; flag_m = ~it[2]; flag_q = it[5];
         cur_pc   = 32'h0C01_0000 + it * 32'h24;
         cur_r15  = 32'h8CFF_F000 - it * 32'h10;
         evt_code = 12'h0E0 + 12'(it);
         slot_code = 12'h1A0 + 12'(it);
         trap_imm = 8'(it * 7 + 3);
         vbr_we   = it[0];
         vbr_wdata = 32'hDEAD_0000;
         model_req(it[2:0], it[3], vb);
         if (it[0] && !(m_done && (it[2:0] == 3'd4 || cur_sr[28]))) m_vbr = 32'hDEAD_0000;
         @(negedge clk);
         idle_inputs();
         if (it[2:0] > 3'd4)      check_all("R10");
         else if (it[2:0] == 3'd4) check_all("R8");
         else if (cur_sr[28])     check_all("R9");
         else if (it[2:0] == 3'd3) check_all("R6");
         else if (it[2:0] == 3'd2) check_all("R7");
         else if (it[3])          check_all("R5");
         else                     check_all("R4");
         chk("R2", "ssr", ssr, m_ssr);
         chk("R3", "new_sr", new_sr, m_sr);
         // one idle cycle: pulses drop, state holds (R11, R10)
         @(negedge clk);
         m_done = 0; m_slot = 0;
         check_all("R11");
      end

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule